// File: doc/BRIEF.md
# DRAM Bank Command Timing Scheduler

This block sequences commands for one DRAM bank under an open-row policy. A requester presents a read or write with a row and a column and holds it until the scheduler accepts it. The scheduler keeps at most one row open. From that row state it picks one of three paths: a column command at once (row hit), an activate and then a column command (no row open), or a precharge, an activate and then a column command (a different row is open).

Every command waits until all of its timing limits have been met, and then issues in the first legal cycle. Each limit has its own counter, driven by run-time parameter inputs counted in clock cycles. A read-data-valid strobe appears a CAS-latency number of cycles after each read command. The path a request took is reported with its column command.

Top module: `dram_bank_sched`

## Requirements
- R1: After reset no row is open, every timing limit counts as already met, `cmd_o` is NOP (3'd0), `req_ready_o` and `rd_valid_o` are low, and the first request takes the closed-row path.
- R2: `cmd_o` encodes NOP=0, ACT=1, RD=2, WR=3, PRE=4, and at most one command issues per cycle. `req_ready_o` is high only in the cycle that issues the column command (RD or WR) for the presented request.
- R3: A RD or WR issues no earlier than t_rcd cycles after the ACT that opened the row.
- R4: An ACT issues no earlier than t_rp cycles after the last PRE, and no earlier than t_ras + t_rp cycles after the previous ACT.
- R5: A PRE issues no earlier than t_ras cycles after the ACT that opened the row.
- R6: A PRE issues no earlier than t_wr cycles after the last WR to the open row.
- R7: `rd_valid_o` is high exactly t_cl cycles after each RD cycle (a t_cl of 0 acts as 1), and is low in all other cycles.
- R8: A request to the open row issues its column command directly, with `acc_type_o` = 2'd1 (hit).
- R9: A request with no row open issues ACT and then the column command, with `acc_type_o` = 2'd2 (closed).
- R10: A request to a row other than the open one issues PRE, then ACT, then the column command, with `acc_type_o` = 2'd3 (conflict). `acc_type_o` is 2'd0 in every cycle without a column command.
- R11: A timing parameter of 0 or 1 allows the dependent command in the cycle right after its trigger.
- R12: While a request is valid, each command issues in the first cycle that all of its limits allow, and NOP is driven in every cycle before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A request is presented |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_row_i | input | ROW_W | Request row address |
| req_col_i | input | COL_W | Request column address |
| t_cl_i | input | TW | Read latency in cycles |
| t_rcd_i | input | TW | Minimum cycles from activate to column command |
| t_rp_i | input | TW | Minimum cycles from precharge to activate |
| t_ras_i | input | TW | Minimum cycles from activate to precharge |
| t_wr_i | input | TW | Minimum cycles from last write to precharge |
| req_ready_o | output | 1 | Request accepted this cycle |
| cmd_o | output | 3 | Command issued this cycle |
| cmd_row_o | output | ROW_W | Row carried by the command |
| cmd_col_o | output | COL_W | Column carried by the command |
| rd_valid_o | output | 1 | Read data valid strobe |
| acc_type_o | output | 2 | Path taken, given with the column command |

## Verification
The hardest case to reach is a precharge held back by the write-recovery limit rather than by the row-active limit, because it needs a write to the open row followed at once by a conflicting request while t_wr is larger than the time left on t_ras. The bench sweeps small combinations of all five parameters, including 0 and 1, over a fixed request pattern with back-to-back hit, closed and conflict requests. For every cycle it computes arithmetically the earliest legal cycle of the next command, so each case in which one limit dominates the others shows up in some combination.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ACC_NONE     = 2'd0,
    ACC_HIT      = 2'd1,
    ACC_CLOSED   = 2'd2,
    ACC_CONFLICT = 2'd3
  } acc_e;

  // timing counter slots
  localparam int T_RCD = 0;
  localparam int T_RP  = 1;
  localparam int T_RAS = 2;
  localparam int T_WR  = 3;
  localparam int N_TCNT = 4;
endpackage

// File: rtl/sched_cnt.sv
module sched_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         ok_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  // value v loaded at cycle t allows the next command at cycle t+max(v,1)
  assign ok_o = (cnt_q <= W'(1));

  p_cnt_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - W'(1)));

  p_cnt_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && val_i <= W'(1)) |=> ok_o);
endmodule

// File: rtl/sched_rd_pipe.sv
module sched_rd_pipe #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [TW-1:0] lat_i,
  output logic          valid_o
);
  localparam int DEPTH = 1 << TW;

  logic [DEPTH-1:0] pipe_q;
  logic [TW-1:0]    slot;

  assign slot = (lat_i == '0) ? '0 : lat_i - TW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= (pipe_q >> 1) | (rd_i ? (DEPTH'(1) << slot) : '0);
  end

  assign valid_o = pipe_q[0];

  p_short_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && lat_i <= TW'(1)) |=> valid_o);
endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
  import dram_sched_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int TW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [TW-1:0]    t_cl_i,
  input  logic [TW-1:0]    t_rcd_i,
  input  logic [TW-1:0]    t_rp_i,
  input  logic [TW-1:0]    t_ras_i,
  input  logic [TW-1:0]    t_wr_i,
  output logic             req_ready_o,
  output logic [2:0]       cmd_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic             rd_valid_o,
  output logic [1:0]       acc_type_o
);
  localparam int TC_W    = TW + 1;
  localparam int SINCE_W = TW + 2;

  logic             row_open_q;
  logic [ROW_W-1:0] open_row_q;
  logic             saw_pre_q, saw_act_q;

  logic   row_hit;
  cmd_e   cmd;
  logic   iss_act, iss_pre, iss_rd, iss_wr, iss_col;

  logic [N_TCNT-1:0] t_load, t_ok;
  logic [TW-1:0]     t_val [N_TCNT];
  logic              rc_ok;

  assign row_hit = row_open_q && (open_row_q == req_row_i);

  always_comb begin
    cmd = CMD_NOP;
    if (req_valid_i) begin
      if (row_hit) begin
        if (t_ok[T_RCD]) cmd = req_we_i ? CMD_WR : CMD_RD;
      end else if (row_open_q) begin
        if (t_ok[T_RAS] && t_ok[T_WR]) cmd = CMD_PRE;
      end else begin
        if (t_ok[T_RP] && rc_ok) cmd = CMD_ACT;
      end
    end
  end

  assign iss_act = (cmd == CMD_ACT);
  assign iss_pre = (cmd == CMD_PRE);
  assign iss_rd  = (cmd == CMD_RD);
  assign iss_wr  = (cmd == CMD_WR);
  assign iss_col = iss_rd | iss_wr;

  // per-limit counters
  assign t_load[T_RCD] = iss_act;
  assign t_val[T_RCD]  = t_rcd_i;
  assign t_load[T_RP]  = iss_pre;
  assign t_val[T_RP]   = t_rp_i;
  assign t_load[T_RAS] = iss_act;
  assign t_val[T_RAS]  = t_ras_i;
  assign t_load[T_WR]  = iss_wr;
  assign t_val[T_WR]   = t_wr_i;

  for (genvar g = 0; g < N_TCNT; g++) begin : g_tcnt
    sched_cnt #(.W(TW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (t_load[g]),
      .val_i  (t_val[g]),
      .ok_o   (t_ok[g])
    );
  end

  // activate-to-activate spacing
  sched_cnt #(.W(TC_W)) u_rc_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (iss_act),
    .val_i  (TC_W'(t_ras_i) + TC_W'(t_rp_i)),
    .ok_o   (rc_ok)
  );

  sched_rd_pipe #(.TW(TW)) u_rd_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (iss_rd),
    .lat_i   (t_cl_i),
    .valid_o (rd_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_open_q <= 1'b0;
      open_row_q <= '0;
      saw_pre_q  <= 1'b0;
      saw_act_q  <= 1'b0;
    end else begin
      if (iss_pre) begin
        row_open_q <= 1'b0;
        saw_pre_q  <= 1'b1;
      end
      if (iss_act) begin
        row_open_q <= 1'b1;
        open_row_q <= req_row_i;
        saw_act_q  <= 1'b1;
      end
      if (iss_col) begin
        saw_pre_q <= 1'b0;
        saw_act_q <= 1'b0;
      end
    end
  end

  always_comb begin
    acc_type_o = ACC_NONE;
    if (iss_col) begin
      if (saw_pre_q)      acc_type_o = ACC_CONFLICT;
      else if (saw_act_q) acc_type_o = ACC_CLOSED;
      else                acc_type_o = ACC_HIT;
    end
  end

  assign req_ready_o = iss_col;
  assign cmd_o       = cmd;
  assign cmd_row_o   = (cmd != CMD_NOP) ? req_row_i : '0;
  assign cmd_col_o   = iss_col ? req_col_i : '0;

  // elapsed-cycle trackers, used only by the checks below
  logic [SINCE_W-1:0] since_act_q, since_pre_q, since_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_q <= '1;
      since_pre_q <= '1;
      since_wr_q  <= '1;
    end else begin
      since_act_q <= iss_act ? SINCE_W'(1) : ((since_act_q == '1) ? since_act_q : since_act_q + SINCE_W'(1));
      since_pre_q <= iss_pre ? SINCE_W'(1) : ((since_pre_q == '1) ? since_pre_q : since_pre_q + SINCE_W'(1));
      since_wr_q  <= iss_wr  ? SINCE_W'(1) : ((since_wr_q  == '1) ? since_wr_q  : since_wr_q  + SINCE_W'(1));
    end
  end

  p_ready_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (req_valid_i && (cmd_o == 3'd2 || cmd_o == 3'd3)));

  p_col_after_rcd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_col |-> (since_act_q >= SINCE_W'(t_rcd_i)));

  p_act_after_rp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_act |-> (since_pre_q >= SINCE_W'(t_rp_i)));

  p_act_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_act |-> (since_act_q >= SINCE_W'(t_ras_i) + SINCE_W'(t_rp_i)));

  p_pre_after_ras_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_pre |-> (since_act_q >= SINCE_W'(t_ras_i)));

  p_pre_after_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_pre |-> (since_wr_q >= SINCE_W'(t_wr_i)));

  p_conflict_path_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_pre |=> !row_open_q);

  p_hit_type_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_type_o != 2'd0) |-> iss_col);
endmodule

// File: tb/sim_dram_bank_sched.sv
module sim_dram_bank_sched;
  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int TW    = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_we = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [TW-1:0]    t_cl = 4'd1, t_rcd = 4'd1, t_rp = 4'd1, t_ras = 4'd1, t_wr = 4'd1;
  logic             req_ready;
  logic [2:0]       cmd;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic             rd_valid;
  logic [1:0]       acc_type;

  dram_bank_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_row_i(req_row), .req_col_i(req_col),
    .t_cl_i(t_cl), .t_rcd_i(t_rcd), .t_rp_i(t_rp), .t_ras_i(t_ras), .t_wr_i(t_wr),
    .req_ready_o(req_ready), .cmd_o(cmd), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .rd_valid_o(rd_valid), .acc_type_o(acc_type)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_rv [64];

  // bench model of bank state
  int m_open, m_row, t_act, t_pre, t_wr_last;

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // R7: read-valid strobe compared every cycle
  always @(negedge clk) begin
    #2;
    if (rst_ni) begin
      chk(rd_valid == exp_rv[cyc % 64], "R7", int'(rd_valid), int'(exp_rv[cyc % 64]));
      exp_rv[cyc % 64] = 1'b0;
    end
  end

  task automatic do_reset(input int cl, input int rcd, input int rp, input int ras, input int wr);
    rst_ni = 1'b0;
    req_valid = 1'b0;
    t_cl = TW'(cl); t_rcd = TW'(rcd); t_rp = TW'(rp); t_ras = TW'(ras); t_wr = TW'(wr);
    foreach (exp_rv[i]) exp_rv[i] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(cmd == 3'd0, "R1", int'(cmd), 0);
    chk(req_ready == 1'b0, "R1", int'(req_ready), 0);
    chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
    m_open = 0; m_row = 0;
    t_act = -1000; t_pre = -1000; t_wr_last = -1000;
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      #1;
      chk(cmd == 3'd0, "R12", int'(cmd), 0);
      @(negedge clk);
    end
  endtask

  // present one request; called right after a falling edge
  task automatic issue(input bit we, input int row, input int col);
    int kind_exp;
    int ec, e;
    bit done;
    string tag;
    done = 0;
    if (m_open != 0 && m_row == row) kind_exp = 1;
    else if (m_open != 0)           kind_exp = 3;
    else                            kind_exp = 2;
    req_valid = 1'b1; req_we = we; req_row = ROW_W'(row); req_col = COL_W'(col);
    for (int i = 0; i < 200; i++) begin
      #1;
      if (m_open != 0 && m_row == row) begin
        ec = we ? 3 : 2;
        e = t_act + mx(int'(t_rcd), 1);
        tag = (t_rcd <= 1) ? "R11" : "R3";
      end else if (m_open != 0) begin
        ec = 4;
        e = mx(t_act + mx(int'(t_ras), 1), t_wr_last + mx(int'(t_wr), 1));
        tag = "R5/R6";
      end else begin
        ec = 1;
        e = mx(t_pre + mx(int'(t_rp), 1), t_act + mx(int'(t_ras) + int'(t_rp), 1));
        tag = "R4";
      end
      if (cyc >= e) begin
        chk(int'(cmd) == ec, tag, int'(cmd), ec);
        chk(cmd_row == ROW_W'(row), "R2", int'(cmd_row), row);
        case (ec)
          1: begin m_open = 1; m_row = row; t_act = cyc; end
          4: begin m_open = 0; t_pre = cyc; end
          default: begin
            if (ec == 3) t_wr_last = cyc;
            else exp_rv[(cyc + mx(int'(t_cl), 1)) % 64] = 1'b1;
            chk(req_ready == 1'b1, "R2", int'(req_ready), 1);
            chk(cmd_col == COL_W'(col), "R2", int'(cmd_col), col);
            chk(int'(acc_type) == kind_exp,
                (kind_exp == 1) ? "R8" : ((kind_exp == 2) ? "R9" : "R10"),
                int'(acc_type), kind_exp);
            done = 1;
          end
        endcase
        if (ec == 1 || ec == 4) begin
          chk(req_ready == 1'b0, "R2", int'(req_ready), 0);
          chk(acc_type == 2'd0, "R10", int'(acc_type), 0);
        end
      end else begin
        chk(cmd == 3'd0, "R12", int'(cmd), 0);
        chk(req_ready == 1'b0, "R12", int'(req_ready), 0);
      end
      @(negedge clk);
      if (done) break;
    end
    if (!done) chk(1'b0, "R12", 0, 1);
    req_valid = 1'b0;
  endtask

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cls[2]  = '{1, 3};
    int rcds[3] = '{0, 1, 3};
    int rps[2]  = '{0, 2};
    int rass[2] = '{1, 4};
    int wrs[2]  = '{0, 3};
    // sweep includes 0 and 1 for R11
    foreach (cls[a]) foreach (rcds[b]) foreach (rps[c]) foreach (rass[d]) foreach (wrs[f]) begin
      do_reset(cls[a], rcds[b], rps[c], rass[d], wrs[f]);
      issue(1'b1, 1, 1);   // closed, R1 and R9
      issue(1'b0, 1, 2);   // hit right after activate
      issue(1'b0, 2, 3);   // conflict after write
      issue(1'b1, 2, 4);   // hit
      issue(1'b0, 3, 5);   // conflict right after write, R6
      idle(2);
      issue(1'b0, 3, 6);   // hit after a gap
      issue(1'b0, 3, 7);   // back-to-back reads
      issue(1'b1, 5, 8);   // conflict after reads
      idle(20);
    end
    // CL of zero acts as one
    do_reset(0, 2, 1, 2, 1);
    issue(1'b0, 4, 1);
    issue(1'b0, 4, 2);
    idle(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule